// File: doc/BRIEF.md
# Single-Wire Frame Deserializer with Burst Synchronisation

This block receives a serial word carried on one wire and presents it as a parallel word. It takes two copies of the line. The raw line keeps its short clock pulses, and the block takes the strobes from it. The low-pass-filtered line carries only the slow data level, and the block takes the bit values from it. Every bit on the wire is a wide level, a low gap, and then a short high strobe pulse. The line is low when idle. On each qualified strobe, the block samples the filtered level into a shift chain and advances a position counter. When a whole word has been collected, it copies the chain to the output register in one step, raises a one-cycle valid pulse, and clears the chain so the next word starts clean. The word stays on the outputs until the next word is complete.

Both lines pass through a synchronizer and are examined at the system clock. A strobe is a narrow pulse. Its rising edge must be followed by a low level within a guard window, with no further rising edge in that window. Wide data pulses therefore never clock the chain, and clusters of closely spaced edges yield at most one strobe.

In framed mode, the sender puts a burst of rapid pulses and then a quiet slot in front of each word. The block treats the burst as a sync marker: it clears the counter and the chain and ignores the line until it has been quiet for one quiet interval. Reception therefore aligns to the word boundary even if the receiver starts late. Without framed mode, words are simply cut every eight strobes counted from reset, so a late start gives misaligned words.

Top module: `burstSyncDeser`

## Requirements
- R1: After reset, `wordOut` is all zeros and `wordValid` is low.
- R2: A rising edge on `lineRaw` counts as a data strobe only if the line is low again before `GUARD_CYCLES` cycles have passed and no other rising edge arrives in that time. The bit taken is the level of `lineFilt` at that rising edge. A pulse that is still high when the guard expires is not a strobe.
- R3: When two or more rising edges fall within `GUARD_CYCLES` of each other, only the last of them can become a strobe. At most one bit is shifted per such cluster.
- R4: The first bit of a word ends up in `wordOut[WORD_BITS-1]` and the last bit in `wordOut[0]`.
- R5: On the `WORD_BITS`-th strobe since the last word boundary, `wordOut` takes the new word and `wordValid` is high for exactly one cycle, in the same cycle the outputs change.
- R6: The shift chain and the strobe counter are cleared when a word is latched, so each word depends only on its own strobes.
- R7: `wordOut` does not change in any cycle in which `wordValid` is low.
- R8: With `framedMode` high, a rising edge that is at least the `BURST_EDGES`-th within a window of `BIT_CYCLES` cycles is a sync marker. It clears the chain and the counter, which discards a partly received word.
- R9: After a sync marker, all rising edges are ignored until `QUIET_CYCLES` consecutive cycles pass without one. Each rising edge in that interval restarts the wait.
- R10: With `framedMode` low, no sync marker is ever recognised. Words are cut every `WORD_BITS` strobes counted from reset, so a receiver that starts mid-word delivers words made of bits from two transmitted words.
- R11: The edges of a sync burst never shift a bit into the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| framedMode | input | 1 | 1 = recognise burst sync markers |
| lineRaw | input | 1 | Unfiltered line; strobes are taken from it |
| lineFilt | input | 1 | Low-pass-filtered line; data level |
| wordOut | output | WORD_BITS | Last complete word, held between updates |
| wordValid | output | 1 | One-cycle pulse when `wordOut` updates |

## Verification
The bench mixes random words with the all-zero, all-one, and single-set-bit patterns, and sends some bits as doubled strobe pulses. A design that qualified edges too eagerly would shift two bits for a doubled strobe, or a spurious bit at the start of a wide high data level. In unframed mode it starts three bits into the stream and expects the misaligned words that follow from counting strobes since reset. A design that cleared its counter on some other cue would deliver aligned words there. In framed mode it breaks off a word halfway and then sends a sync burst. It also places a stray strobe inside the quiet slot after a burst. A design that let burst or quiet-slot edges reach the chain would deliver shifted words or an extra word.

// File: rtl/burstSyncPkg.sv
package burstSyncPkg;

  typedef struct packed {
    logic shiftEn;
    logic latchEn;
    logic clearEn;
  } ctlStrobes_t;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_SYNC = 1'b1
  } rxState_t;

endpackage

// File: rtl/burstSyncData.sv
module burstSyncData
  import burstSyncPkg::*;
#(
  parameter int WORD_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineRaw,
  input  logic                 lineFilt,
  input  ctlStrobes_t          ctl,
  output logic                 rawRise,
  output logic                 rawLevel,
  output logic [WORD_BITS-1:0] wordOut,
  output logic                 wordValid
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] rawSync;
  logic [SYNC_STAGES-1:0] filtSync;
  logic                   rawPrev;
  logic                   pendBit;
  logic [WORD_BITS-1:0]   chain;
  logic [WORD_BITS-1:0]   outReg;
  logic                   validReg;

  // synchronizer stages for both line copies
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) begin
          rawSync[0]  <= 1'b0;
          filtSync[0] <= 1'b0;
        end else begin
          rawSync[0]  <= lineRaw;
          filtSync[0] <= lineFilt;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) begin
          rawSync[s]  <= 1'b0;
          filtSync[s] <= 1'b0;
        end else begin
          rawSync[s]  <= rawSync[s-1];
          filtSync[s] <= filtSync[s-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rawPrev <= 1'b0;
    else       rawPrev <= rawSync[LAST];
  end

  assign rawLevel = rawSync[LAST];
  assign rawRise  = rawSync[LAST] & ~rawPrev;

  // data level captured at the edge that may become a strobe
  always_ff @(posedge clk) begin
    if (!rstN)        pendBit <= 1'b0;
    else if (rawRise) pendBit <= filtSync[LAST];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain    <= '0;
      outReg   <= '0;
      validReg <= 1'b0;
    end else begin
      validReg <= 1'b0;
      if (ctl.latchEn) begin
        outReg   <= {chain[WORD_BITS-2:0], pendBit};
        validReg <= 1'b1;
        chain    <= '0;
      end else if (ctl.clearEn) begin
        chain <= '0;
      end else if (ctl.shiftEn) begin
        chain <= {chain[WORD_BITS-2:0], pendBit};
      end
    end
  end

  assign wordOut   = outReg;
  assign wordValid = validReg;

  a_r6_latch_clears_chain: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchEn |=> (chain == '0) && validReg);

  a_r8_sync_clears_chain: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clearEn && !ctl.latchEn) |=> chain == '0);

  a_r7_output_holds: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchEn |=> $stable(outReg));

  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    validReg |=> !validReg);

endmodule

// File: rtl/burstSyncCtrl.sv
module burstSyncCtrl
  import burstSyncPkg::*;
#(
  parameter int WORD_BITS    = 8,
  parameter int BIT_CYCLES   = 250,
  parameter int GUARD_CYCLES = 16,
  parameter int QUIET_CYCLES = 250,
  parameter int BURST_EDGES  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        framedMode,
  input  logic        rawRise,
  input  logic        rawLevel,
  output ctlStrobes_t ctl
);

  localparam int GW = (GUARD_CYCLES > 1) ? $clog2(GUARD_CYCLES) : 1;
  localparam int WW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam int QW = (QUIET_CYCLES > 1) ? $clog2(QUIET_CYCLES) : 1;
  localparam int EW = $clog2(BURST_EDGES + 1);
  localparam int CW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;

  localparam logic [GW-1:0] GUARD_LAST = GW'(GUARD_CYCLES - 1);
  localparam logic [WW-1:0] WIN_LAST   = WW'(BIT_CYCLES - 1);
  localparam logic [QW-1:0] QUIET_LAST = QW'(QUIET_CYCLES - 1);
  localparam logic [EW-1:0] EDGE_MAX   = EW'(BURST_EDGES);
  localparam logic [EW-1:0] EDGE_HIT   = EW'(BURST_EDGES - 1);
  localparam logic [CW-1:0] BIT_LAST   = CW'(WORD_BITS - 1);

  // strobe qualification
  logic          pendValid;
  logic          sawLow;
  logic [GW-1:0] guardCnt;
  logic          guardEnd;
  logic          commit;

  // burst window
  logic          winActive;
  logic [WW-1:0] winCnt;
  logic [EW-1:0] winEdges;
  logic          winEnd;
  logic          burstHit;

  // sync and position
  rxState_t      state;
  logic [QW-1:0] quietCnt;
  logic [CW-1:0] bitCnt;
  logic          commitOk;
  logic          lastBit;

  assign guardEnd = (guardCnt == GUARD_LAST);
  assign commit   = pendValid && guardEnd && !rawRise && (sawLow || !rawLevel);
  assign commitOk = commit && (state == ST_RUN);
  assign lastBit  = (bitCnt == BIT_LAST);

  assign winEnd   = (winCnt == WIN_LAST);
  assign burstHit = framedMode && rawRise && winActive && !winEnd && (winEdges >= EDGE_HIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      sawLow    <= 1'b0;
      guardCnt  <= '0;
    end else if (rawRise) begin
      pendValid <= 1'b1;
      sawLow    <= 1'b0;
      guardCnt  <= '0;
    end else if (pendValid) begin
      if (!rawLevel) sawLow <= 1'b1;
      if (guardEnd) pendValid <= 1'b0;
      else          guardCnt  <= guardCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winActive <= 1'b0;
      winCnt    <= '0;
      winEdges  <= '0;
    end else if (rawRise && (!winActive || winEnd)) begin
      winActive <= 1'b1;
      winCnt    <= '0;
      winEdges  <= EW'(1);
    end else if (winActive) begin
      if (winEnd) begin
        winActive <= 1'b0;
      end else begin
        winCnt <= winCnt + 1'b1;
        if (rawRise && (winEdges != EDGE_MAX)) winEdges <= winEdges + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_RUN;
      quietCnt <= '0;
    end else if (burstHit) begin
      state    <= ST_SYNC;
      quietCnt <= '0;
    end else if (state == ST_SYNC) begin
      if (rawRise)         quietCnt <= '0;
      else if (quietCnt == QUIET_LAST) state <= ST_RUN;
      else                 quietCnt <= quietCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         bitCnt <= '0;
    else if (burstHit) bitCnt <= '0;
    else if (commitOk) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
  end

  always_comb begin
    ctl         = '0;
    ctl.shiftEn = commitOk;
    ctl.latchEn = commitOk && lastBit;
    ctl.clearEn = burstHit;
  end

  a_r9_no_shift_while_sync: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SYNC) |-> !ctl.shiftEn);

  a_r3_one_strobe_per_cluster: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftEn |=> !ctl.shiftEn);

  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_LAST);

  a_r8_sync_entry: assert property (@(posedge clk) disable iff (!rstN)
    burstHit |=> (state == ST_SYNC) && (bitCnt == '0));

  a_r10_no_sync_unframed: assert property (@(posedge clk) disable iff (!rstN)
    !framedMode |-> !ctl.clearEn);

endmodule

// File: rtl/burstSyncDeser.sv
module burstSyncDeser
  import burstSyncPkg::*;
#(
  parameter int WORD_BITS    = 8,
  parameter int BIT_CYCLES   = 250,
  parameter int GUARD_CYCLES = 16,
  parameter int QUIET_CYCLES = 250,
  parameter int BURST_EDGES  = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 framedMode,
  input  logic                 lineRaw,
  input  logic                 lineFilt,
  output logic [WORD_BITS-1:0] wordOut,
  output logic                 wordValid
);

  ctlStrobes_t ctl;
  logic        rawRise;
  logic        rawLevel;

  burstSyncData #(
    .WORD_BITS  (WORD_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .lineRaw  (lineRaw),
    .lineFilt (lineFilt),
    .ctl      (ctl),
    .rawRise  (rawRise),
    .rawLevel (rawLevel),
    .wordOut  (wordOut),
    .wordValid(wordValid)
  );

  burstSyncCtrl #(
    .WORD_BITS   (WORD_BITS),
    .BIT_CYCLES  (BIT_CYCLES),
    .GUARD_CYCLES(GUARD_CYCLES),
    .QUIET_CYCLES(QUIET_CYCLES),
    .BURST_EDGES (BURST_EDGES)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .framedMode(framedMode),
    .rawRise   (rawRise),
    .rawLevel  (rawLevel),
    .ctl       (ctl)
  );

endmodule

// File: tb/test_burstSyncDeser.sv
module test_burstSyncDeser;

  localparam int WB = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          framedMode = 1'b0;
  logic          lineRaw = 1'b0;
  logic          lineFilt = 1'b0;
  logic [WB-1:0] wordOut;
  logic          wordValid;

  int checks = 0;
  int fails = 0;

  int expW [0:255];
  int obsW [0:255];
  int expN = 0;
  int obsN = 0;
  logic [WB-1:0] mChain = '0;
  int mCnt = 0;
  int holdErr = 0;
  int pulseErr = 0;
  logic [WB-1:0] lastOut = '0;
  logic lastValid = 1'b0;

  always #5 clk = ~clk;

  burstSyncDeser #(
    .WORD_BITS   (WB),
    .BIT_CYCLES  (36),
    .GUARD_CYCLES(6),
    .QUIET_CYCLES(36),
    .BURST_EDGES (4),
    .SYNC_STAGES (2)
  ) i_burstSyncDeser (
    .clk       (clk),
    .rstN      (rstN),
    .framedMode(framedMode),
    .lineRaw   (lineRaw),
    .lineFilt  (lineFilt),
    .wordOut   (wordOut),
    .wordValid (wordValid)
  );

  // monitor: collects words, watches hold (R7) and pulse width (R5)
  always @(negedge clk) begin
    if (!rstN) begin
      lastOut   <= wordOut;
      lastValid <= 1'b0;
    end else begin
      if (wordValid) begin
        if (obsN < 256) obsW[obsN] <= int'(wordOut);
        obsN <= obsN + 1;
      end else if (wordOut != lastOut) begin
        holdErr <= holdErr + 1;
      end
      if (wordValid && lastValid) pulseErr <= pulseErr + 1;
      lastOut   <= wordOut;
      lastValid <= wordValid;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic f, input int n);
    #1;
    lineRaw  = r;
    lineFilt = f;
    repeat (n) @(posedge clk);
  endtask

  function automatic void modelBit(input logic b);
    mChain = {mChain[WB-2:0], b};
    mCnt++;
    if (mCnt == WB) begin
      expW[expN] = int'(mChain);
      expN++;
      mChain = '0;
      mCnt = 0;
    end
  endfunction

  task automatic sendBit(input logic b);
    step(b, b, 20);
    step(1'b0, b, 8);
    step(1'b1, b, 2);
    step(1'b0, b, 6);
    modelBit(b);
  endtask

  // doubled strobe pulse: only one bit expected (R3)
  task automatic sendDouble(input logic b);
    step(b, b, 20);
    step(1'b0, b, 8);
    step(1'b1, b, 2);
    step(1'b0, b, 2);
    step(1'b1, b, 2);
    step(1'b0, b, 6);
    modelBit(b);
  endtask

  task automatic sendWord(input logic [WB-1:0] w, input bit dbl);
    for (int i = WB - 1; i >= 0; i--) begin
      if (dbl && (i % 3 == 0)) sendDouble(w[i]);
      else                     sendBit(w[i]);
    end
  endtask

  task automatic sendBurst(input bit stray);
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b1, 2);
      step(1'b0, 1'b1, 2);
    end
    if (stray) begin
      step(1'b0, 1'b1, 10);
      step(1'b1, 1'b1, 2);
    end
    step(1'b0, 1'b0, 44);
    if (framedMode) begin
      mChain = '0;
      mCnt = 0;
    end
  endtask

  task automatic doReset;
    #1;
    rstN = 1'b0;
    lineRaw = 1'b0;
    lineFilt = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    rstN = 1'b1;
    mChain = '0;
    mCnt = 0;
    expN = 0;
    obsN = 0;
  endtask

  task automatic compare(input string req);
    step(1'b0, 1'b0, 40);
    check(obsN == expN, {req, " word count"}, obsN, expN);
    for (int i = 0; i < expN && i < obsN; i++)
      check(obsW[i] == expW[i], req, obsW[i], expW[i]);
  endtask

  initial begin
    void'($urandom(32'd24681));
    doReset();
    @(negedge clk);
    check(wordOut == '0, "R1 reset word", int'(wordOut), 0);
    check(wordValid == 1'b0, "R1 reset valid", int'(wordValid), 0);

    // R2 R4 R5 R6: aligned unframed words, directed and random
    framedMode = 1'b0;
    sendWord(8'h80, 1'b0);
    sendWord(8'h01, 1'b0);
    sendWord(8'hFF, 1'b0);
    sendWord(8'h00, 1'b0);
    for (int n = 0; n < 4; n++) sendWord(WB'($urandom), 1'b0);
    compare("R2/R4 unframed words");

    // R3: doubled strobe pulses give one bit each
    doReset();
    for (int n = 0; n < 3; n++) sendWord(WB'($urandom), 1'b1);
    sendWord(8'hA5, 1'b1);
    compare("R3 doubled strobes");

    // R10: late start in unframed mode gives misaligned words
    doReset();
    sendBit(1'b1);
    sendBit(1'b0);
    sendBit(1'b1);
    for (int n = 0; n < 4; n++) sendWord(WB'($urandom), 1'b0);
    compare("R10 misaligned");

    // R8 R11: framed words each preceded by a burst
    doReset();
    framedMode = 1'b1;
    sendBurst(1'b0); sendWord(8'hFF, 1'b0);
    sendBurst(1'b0); sendWord(8'h00, 1'b0);
    for (int n = 0; n < 4; n++) begin
      sendBurst(1'b0);
      sendWord(WB'($urandom), 1'b0);
    end
    compare("R11 framed words");

    // R8: burst discards a partial word and realigns
    doReset();
    framedMode = 1'b1;
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    sendBurst(1'b0); sendWord(8'h3C, 1'b0);
    sendBurst(1'b0); sendWord(WB'($urandom), 1'b0);
    compare("R8 resync");

    // R9: stray strobe inside the quiet slot is ignored
    doReset();
    framedMode = 1'b1;
    sendBurst(1'b1); sendWord(8'h5A, 1'b0);
    sendBurst(1'b1); sendWord(WB'($urandom), 1'b0);
    compare("R9 quiet slot");

    check(holdErr == 0, "R7 output held", holdErr, 0);
    check(pulseErr == 0, "R5 valid one cycle", pulseErr, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule